// File: doc/BRIEF.md
# Integer Arithmetic/Logic Unit with Status Flag Register

This block performs one integer operation per clock on two 16-bit operands, or on their low bytes when byte mode is selected, and keeps a 16-bit flag word alongside the result. The supported operations are add, add-with-carry, subtract, subtract-with-borrow, compare, AND, OR and XOR. The carry held in the flag word feeds the two chained operations, so a wide add or subtract can be built from a sequence of operations.

Each operation is sampled on a rising clock edge. The result register and the six status flags change on that edge. The status flags change only when the flag-write enable is high. The three control flags are not touched by any operation. They change only through a separate load input, so the surrounding control logic has one path to them and the data path never reaches them.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset, `result` and `flag_word` are both 0.
- R2: When `op_valid` is high at a clock edge, `result` shows the operation's value after that edge. The `op_code` encodings are: 0 add, 1 OR, 2 add with carry, 3 subtract with borrow, 4 AND, 5 subtract, 6 XOR, 7 compare. Subtraction computes `opa` minus `opb`.
- R3: Compare (7) sets the status flags exactly as subtract would, and leaves `result` unchanged.
- R4: With `byte_mode` high, the operation uses bits 7:0 of the operands. `result[15:8]` becomes 0, and every flag is taken from the 8-bit result: carry out of bit 7 and sign from bit 7.
- R5: Flag bit 0 (carry) is the carry out of the result's top bit for additions, and the borrow for subtract, subtract-with-borrow and compare. Add-with-carry adds the stored carry, and subtract-with-borrow subtracts it.
- R6: Flag bit 2 (parity) is 1 when bits 7:0 of the result hold an even number of ones, in both byte and word mode.
- R7: Flag bit 4 (auxiliary) is the carry out of bit 3 for additions, or the borrow out of bit 3 for subtractions. Logic operations clear it.
- R8: Flag bit 6 (zero) is 1 when the operation's result is 0. Flag bit 7 (sign) equals the result's top bit.
- R9: Flag bit 11 (overflow) is set on an addition when both operands have the same sign and the result's sign differs from it. It is set on a subtraction when the operands' signs differ and the result's sign differs from the minuend's sign.
- R10: AND, OR and XOR clear the carry and overflow flags.
- R11: When `flag_we` is low, or `op_valid` is low, the six status flags keep their values. The result still updates when `op_valid` is high.
- R12: Flag bits 8, 9 and 10 take `ctl_bits[0]`, `ctl_bits[1]` and `ctl_bits[2]` on an edge where `ctl_load` is high, and otherwise hold. No operation changes them.
- R13: Flag bits 1, 3, 5 and 15:12 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Perform the operation on this edge |
| op_code | input | 3 | Operation select (see R2) |
| byte_mode | input | 1 | 1 selects 8-bit operation on the low bytes |
| flag_we | input | 1 | Allow the operation to update the status flags |
| opa | input | 16 | First operand (minuend for subtraction) |
| opb | input | 16 | Second operand |
| ctl_load | input | 1 | Load the control flags from ctl_bits |
| ctl_bits | input | 3 | New control flag values for bits 8, 9, 10 |
| result | output | 16 | Registered result |
| flag_word | output | 16 | Registered flag word |

## Verification
A set of directed operand pairs pins the corner values, each against a literal flag word:
- a signed-overflow add at the word sign boundary;
- a zero-minus-one borrow;
- an equal-operand compare;
- a byte add that wraps to zero with overflow;
- a nibble carry that isolates the auxiliary flag;
- a word result whose low byte is zero, which shows that parity ignores the high byte.

These cases separate carry from borrow polarity, byte-lane from word-lane flag sources, and parity over the low byte from parity over the whole word. A long run of mixed random operations, widths, write enables and control loads then follows. It is compared on every clock against an integer model of the flag rules, which exposes any mix-up between the stored carry and the carry-in of chained operations.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int FLAG_W = 16;

    localparam int CF_BIT = 0;
    localparam int PF_BIT = 2;
    localparam int AF_BIT = 4;
    localparam int ZF_BIT = 6;
    localparam int SF_BIT = 7;
    localparam int TF_BIT = 8;
    localparam int IF_BIT = 9;
    localparam int DF_BIT = 10;
    localparam int OF_BIT = 11;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_OR  = 3'd1,
        OP_ADC = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_SUB = 3'd5,
        OP_XOR = 3'd6,
        OP_CMP = 3'd7
    } op_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W     = 16,
    parameter int NIB_W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin_req,
    output logic [W-1:0] sum,
    output logic         cy,
    output logic         aux,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic         cin;
    logic [W:0]   wide;
    logic [W-1:0] xr;

    always_comb begin
        b_eff = sub ? ~b : b;
        // subtraction: a + ~b + (1 - borrow_in)
        cin   = cin_req ^ sub;
        wide  = {1'b0, a} + {1'b0, b_eff} + (W+1)'(cin);
        sum   = wide[W-1:0];
        xr    = a ^ b_eff ^ sum;
        // carry polarity is inverted to give borrow on subtraction
        cy    = wide[W] ^ sub;
        aux   = xr[NIB_W] ^ sub;
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_flag_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int NIB_W  = 4,
    parameter int CTL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic              byte_mode,
    input  logic              flag_we,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              ctl_load,
    input  logic [CTL_W-1:0]  ctl_bits,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flag_word
);
    localparam int N_LANES = 2;
    localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              cf;
        logic              pf;
        logic              af;
        logic              zf;
        logic              sf;
        logic              of;
        logic [CTL_W-1:0]  ctl;
    } state_t;

    state_t state_d, state_q;

    op_e  op;
    logic is_sub, use_c, is_logic;

    always_comb begin
        op       = op_e'(op_code);
        is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        use_c    = (op == OP_ADC) || (op == OP_SBB);
        is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    end

    // lane 0 is the byte lane, lane 1 the word lane
    logic [DATA_W-1:0] lane_sum [N_LANES];
    logic              lane_cy  [N_LANES];
    logic              lane_aux [N_LANES];
    logic              lane_ovf [N_LANES];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? BYTE_W : DATA_W;
        logic [LW-1:0] s;
        alu_addsub #(.W(LW), .NIB_W(NIB_W)) u_addsub (
            .a       (opa[LW-1:0]),
            .b       (opb[LW-1:0]),
            .sub     (is_sub),
            .cin_req (use_c & state_q.cf),
            .sum     (s),
            .cy      (lane_cy[g]),
            .aux     (lane_aux[g]),
            .ovf     (lane_ovf[g])
        );
        assign lane_sum[g] = DATA_W'(s);
    end

    logic [DATA_W-1:0] logic_res;

    alu_logic #(.W(DATA_W)) u_logic (
        .op  (op),
        .a   (opa),
        .b   (opb),
        .res (logic_res)
    );

    logic [DATA_W-1:0] res_sel;
    logic              msb_sel;
    logic              lane_idx;

    always_comb begin
        lane_idx = !byte_mode;
        if (is_logic)
            res_sel = byte_mode ? (logic_res & BYTE_MASK) : logic_res;
        else
            res_sel = lane_sum[lane_idx];
        msb_sel = byte_mode ? res_sel[BYTE_W-1] : res_sel[DATA_W-1];
    end

    always_comb begin
        state_d = state_q;
        if (op_valid) begin
            if (op != OP_CMP)
                state_d.result = res_sel;
            if (flag_we) begin
                state_d.cf = is_logic ? 1'b0 : lane_cy[lane_idx];
                state_d.of = is_logic ? 1'b0 : lane_ovf[lane_idx];
                state_d.af = is_logic ? 1'b0 : lane_aux[lane_idx];
                state_d.pf = ~^res_sel[BYTE_W-1:0];
                state_d.zf = (res_sel == '0);
                state_d.sf = msb_sel;
            end
        end
        if (ctl_load)
            state_d.ctl = ctl_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_word         = '0;
        flag_word[CF_BIT] = state_q.cf;
        flag_word[PF_BIT] = state_q.pf;
        flag_word[AF_BIT] = state_q.af;
        flag_word[ZF_BIT] = state_q.zf;
        flag_word[SF_BIT] = state_q.sf;
        flag_word[OF_BIT] = state_q.of;
        flag_word[TF_BIT] = state_q.ctl[0];
        flag_word[IF_BIT] = state_q.ctl[1];
        flag_word[DF_BIT] = state_q.ctl[2];
        result            = state_q.result;
    end

    // ---------------- assertions ----------------
    p_ctl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_load |=> $stable(flag_word[DF_BIT:TF_BIT]));

    p_ctl_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_load |=> flag_word[DF_BIT:TF_BIT] == $past(ctl_bits));

    p_undef_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        flag_word[1] == 1'b0 && flag_word[3] == 1'b0 && flag_word[5] == 1'b0
        && flag_word[15:12] == 4'b0);

    p_logic_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && flag_we && (op_code == 3'd1 || op_code == 3'd4 || op_code == 3'd6)
        |=> !flag_word[CF_BIT] && !flag_word[OF_BIT]);

    p_cmp_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 3'd7 |=> $stable(result));

    p_byte_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && byte_mode && op_code != 3'd7 |=> result[DATA_W-1:BYTE_W] == '0);

    p_status_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && flag_we) |=> $stable({flag_word[OF_BIT], flag_word[SF_BIT:0]}));

    p_sign_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && flag_we && !byte_mode && op_code != 3'd7
        |=> flag_word[SF_BIT] == result[DATA_W-1]);

endmodule

// File: tb/alu_flag_unit_tb.sv
`timescale 1ns/1ps
module alu_flag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic        byte_mode = 1'b0;
    logic        flag_we = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        ctl_load = 1'b0;
    logic [2:0]  ctl_bits = '0;
    logic [15:0] result;
    logic [15:0] flag_word;

    int n_checks = 0;
    int n_err = 0;

    // behavioural model state
    int          m_res = 0;
    logic [15:0] m_fw = '0;

    always #2 clk = ~clk;

    alu_flag_unit dut_i (
        .clk, .rst_n, .op_valid, .op_code, .byte_mode, .flag_we,
        .opa, .opb, .ctl_load, .ctl_bits, .result, .flag_word
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input bit v, input int op, input bit bm, input bit we,
                         input int a_in, input int b_in, input bit cl, input int cb);
        int w, mask, half, a, b, c, r, sa, sb, sv;
        bit cf, af, of, lg;
        w    = bm ? 8 : 16;
        mask = (1 << w) - 1;
        half = 1 << (w - 1);
        a    = a_in & mask;
        b    = b_in & mask;
        c    = ((op == 2 || op == 3) && m_fw[0]) ? 1 : 0;
        sa   = (a >= half) ? a - 2 * half : a;
        sb   = (b >= half) ? b - 2 * half : b;
        lg   = (op == 1 || op == 4 || op == 6);
        cf = 0; af = 0; of = 0; r = 0;
        case (op)
            0, 2: begin
                r  = a + b + c;
                cf = (r > mask);
                af = ((a & 15) + (b & 15) + c) > 15;
                sv = sa + sb + c;
                of = (sv >= half) || (sv < -half);
            end
            3, 5, 7: begin
                r  = a - b - c;
                cf = (r < 0);
                af = ((a & 15) - (b & 15) - c) < 0;
                sv = sa - sb - c;
                of = (sv >= half) || (sv < -half);
            end
            1: r = a | b;
            4: r = a & b;
            default: r = a ^ b;
        endcase
        r = r & mask;
        if (v) begin
            if (op != 7) m_res = r;
            if (we) begin
                m_fw[0]  = lg ? 1'b0 : cf;
                m_fw[11] = lg ? 1'b0 : of;
                m_fw[4]  = lg ? 1'b0 : af;
                m_fw[2]  = ($countones(r & 255) % 2) == 0;
                m_fw[6]  = (r == 0);
                m_fw[7]  = ((r >> (w - 1)) & 1) != 0;
            end
        end
        if (cl) begin
            m_fw[8]  = cb[0];
            m_fw[9]  = cb[1];
            m_fw[10] = cb[2];
        end
    endtask

    task automatic step(input bit v, input int op, input bit bm, input bit we,
                        input int a, input int b, input bit cl, input int cb);
        string rtag, stag, ltag;
        op_valid = v; op_code = op[2:0]; byte_mode = bm; flag_we = we;
        opa = a[15:0]; opb = b[15:0]; ctl_load = cl; ctl_bits = cb[2:0];
        @(posedge clk);
        model(v, op, bm, we, a, b, cl, cb);
        #1;
        rtag = (op == 7) ? "R3" : (bm ? "R4" : "R2");
        if (!(v && we)) stag = "R11";
        else stag = "";
        ltag = (v && we && (op == 1 || op == 4 || op == 6)) ? "R10" : "R5";
        chk(rtag, result, m_res[15:0]);
        chk((stag != "") ? stag : ltag, {15'b0, flag_word[0]}, {15'b0, m_fw[0]});
        chk((stag != "") ? stag : "R6", {15'b0, flag_word[2]}, {15'b0, m_fw[2]});
        chk((stag != "") ? stag : "R7", {15'b0, flag_word[4]}, {15'b0, m_fw[4]});
        chk((stag != "") ? stag : "R8", {14'b0, flag_word[7:6]}, {14'b0, m_fw[7:6]});
        chk((stag != "") ? stag : ((ltag == "R10") ? "R10" : "R9"),
            {15'b0, flag_word[11]}, {15'b0, m_fw[11]});
        chk("R12", {13'b0, flag_word[10:8]}, {13'b0, m_fw[10:8]});
        chk("R13", flag_word & 16'hF02A, 16'h0000);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        chk("R1", result, 16'h0000);
        chk("R1", flag_word, 16'h0000);
        rst_n = 1'b1;

        step(1, 0, 0, 1, 'h7FFF, 'h0001, 0, 0);   chk("R9", flag_word, 16'h0894);
        step(1, 5, 0, 1, 'h0000, 'h0001, 0, 0);   chk("R5", flag_word, 16'h0095);
        step(1, 7, 0, 1, 'h0005, 'h0005, 0, 0);   chk("R3", result, 16'hFFFF);
                                                  chk("R3", flag_word, 16'h0044);
        step(1, 0, 1, 1, 'hAB80, 'h1280, 0, 0);   chk("R4", result, 16'h0000);
                                                  chk("R4", flag_word, 16'h0845);
        step(1, 2, 0, 1, 'h0000, 'h0000, 0, 0);   chk("R5", result, 16'h0001);
        step(1, 0, 1, 1, 'h000F, 'h0001, 0, 0);   chk("R7", flag_word, 16'h0010);
        step(1, 6, 0, 1, 'h0100, 'h0000, 0, 0);   chk("R6", flag_word, 16'h0004);
        step(1, 0, 0, 0, 'hFFFF, 'h0001, 0, 0);   chk("R11", result, 16'h0000);
                                                  chk("R11", flag_word, 16'h0004);
        step(0, 0, 0, 1, 'h1234, 'h1111, 1, 5);   chk("R12", flag_word, 16'h0504);
        step(1, 1, 0, 1, 'hFFFF, 'h0000, 0, 0);   chk("R10", flag_word, 16'h0584);

        for (int i = 0; i < 2000; i++) begin
            int rv;
            rv = $urandom;
            step(rv[3:0] != 0, int'(rv[6:4]), rv[7], rv[11:8] != 0,
                 int'($urandom & 16'hFFFF), int'($urandom & 16'hFFFF),
                 rv[15:12] == 0, int'(rv[18:16]));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule